// File: doc/BRIEF.md
# Serial Isolation Bit Arbiter

This block is the per-card half of a bus isolation contest. Many cards sit on one set of open-collector read-data lines. A host finds exactly one card among them by reading an isolation register again and again. Each card holds a wide identifier, which the host side supplies as one vector: a 64-bit serial number followed by an 8-bit checksum. The card walks through that identifier one bit per pair of reads. On each read it either pulls a fixed byte pattern onto the shared lines or stays quiet and senses the two lowest lines. A quiet card that sees a competitor's patterns on both reads of a pair has lost the contest. It flags that loss so the surrounding controller can put it to sleep.

A card that gets through every bit of its identifier without losing is the isolated one. The host then gives it a card number. A wake command with a data value of zero starts a new contest: it clears both flags and sets the bit pointer back to the first identifier bit. Each read is a one-cycle strobe. The drive value appears in the clock cycle after the strobe, and the block samples the resolved lines at the end of that same cycle.

Top module: `isolation_bit_arbiter`

## Requirements
- R1: After reset, `drv_en_o`, `lost_o` and `isolated_o` are 0. Read strobes are ignored until the first `wake_zero_i` pulse.
- R2: On the first read of a pair, a competing card whose current identifier bit is 1 drives 55h with `drv_en_o` high. This lasts for exactly the one cycle that follows the accepted strobe. A card whose bit is 0 stays quiet on this read and records whether the low two lines read 01b.
- R3: On the second read of a pair, a competing card drives AAh if its bit is 1, or if it did not record 01b on the first read. Otherwise it stays quiet and senses the lines.
- R4: A quiet card that recorded 01b on the first read and then senses 10b on the second read sets `lost_o`. It then neither drives nor reacts to strobes until the next `wake_zero_i`.
- R5: Identifier bits are used lowest index first, with one bit per pair of reads. After the pair for bit ID_W-1 ends without a loss, `isolated_o` goes high. `lost_o` and `isolated_o` are never high together.
- R6: While `isolated_o` is high, read strobes cause no drive and the flag stays high.
- R7: `wake_zero_i` clears both flags and any open drive window, and sets the bit pointer back to bit 0. If it arrives in the same cycle as a read strobe, the wake wins and the strobe is discarded.
- R8: A strobe that arrives while a drive window is open is ignored. `drv_en_o` is never high in two consecutive cycles.
- R9: `drv_data_o` is 00h whenever `drv_en_o` is low. `drv_en_o` is high only in the cycle after a strobe that was accepted in the competing state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_zero_i | input | 1 | One-cycle wake command with data zero; starts a contest |
| iso_rd_i | input | 1 | One-cycle read strobe to the isolation register |
| sdl_i | input | 2 | Resolved low two read-data lines, sampled in the drive cycle |
| id_i | input | ID_W | Serial identifier with checksum, bit 0 used first |
| drv_data_o | output | 8 | Byte this card pulls onto the data lines |
| drv_en_o | output | 1 | Drive enable for `drv_data_o` |
| lost_o | output | 1 | Card lost the contest |
| isolated_o | output | 1 | Card won the contest |

## Verification
Two functions can fall in the same cycle: a wake command and the acceptance of a read strobe. The bench raises both inputs on the same edge and then checks that no drive follows. It then runs the full contest from that point without another wake. If the strobe had been taken, the read pairs would be out of step and the winner would come out wrong. A second collision is a strobe held into the open drive window. The bench checks that no second drive cycle appears and that the rest of the contest still picks the expected card.

// File: rtl/iso_pkg.sv
package iso_pkg;
  localparam int PAT_W = 8;
  localparam logic [PAT_W-1:0] PAT_FIRST  = 8'h55;
  localparam logic [PAT_W-1:0] PAT_SECOND = 8'hAA;

  typedef enum logic [1:0] {
    ST_SLEEP   = 2'd0,
    ST_COMPETE = 2'd1,
    ST_LOST    = 2'd2,
    ST_WON     = 2'd3
  } iso_state_t;
endpackage

// File: rtl/iso_bit_cursor.sv
module iso_bit_cursor #(
  parameter int ID_W      = 72,
  parameter bit LSB_FIRST = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            advance,
  input  logic [ID_W-1:0] id_i,
  output logic            cur_bit,
  output logic            last
);
  localparam int PTR_W = (ID_W > 1) ? $clog2(ID_W) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ID_W - 1);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      ptr_q <= '0;
    end else if (advance && ptr_q != PTR_LAST) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  generate
    if (LSB_FIRST) begin : g_lsb
      assign idx = ptr_q;
    end else begin : g_msb
      assign idx = PTR_LAST - ptr_q;
    end
  endgenerate

  assign cur_bit = id_i[idx];
  assign last    = (ptr_q == PTR_LAST);
endmodule

// File: rtl/iso_line_sense.sv
module iso_line_sense (
  input  logic [1:0] sdl_i,
  output logic       hit_first,
  output logic       hit_second
);
  import iso_pkg::*;

  assign hit_first  = (sdl_i == PAT_FIRST[1:0]);
  assign hit_second = (sdl_i == PAT_SECOND[1:0]);
endmodule

// File: rtl/iso_drive_reg.sv
module iso_drive_reg (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic                     drop,
  input  logic                     sel_second,
  input  logic                     en_val,
  output logic [iso_pkg::PAT_W-1:0] drv_data_o,
  output logic                     drv_en_o
);
  import iso_pkg::*;

  logic [PAT_W-1:0] pat;
  assign pat = sel_second ? PAT_SECOND : PAT_FIRST;

  always_ff @(posedge clk) begin
    if (rst || drop) begin
      drv_en_o   <= 1'b0;
      drv_data_o <= '0;
    end else if (load) begin
      drv_en_o   <= en_val;
      drv_data_o <= en_val ? pat : '0;
    end
  end
endmodule

// File: rtl/isolation_bit_arbiter.sv
module isolation_bit_arbiter #(
  parameter int ID_W      = 72,
  parameter bit LSB_FIRST = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wake_zero_i,
  input  logic            iso_rd_i,
  input  logic [1:0]      sdl_i,
  input  logic [ID_W-1:0] id_i,
  output logic [7:0]      drv_data_o,
  output logic            drv_en_o,
  output logic            lost_o,
  output logic            isolated_o
);
  import iso_pkg::*;

  iso_state_t st_q;
  logic win_q;
  logic half_q;
  logic drove_q;
  logic saw_first_q;

  logic cur_bit, last;
  logic hit_first, hit_second;
  logic accept, close, drive_now, lose_now, advance;

  assign accept    = (st_q == ST_COMPETE) && iso_rd_i && !win_q && !wake_zero_i;
  assign close     = win_q && !wake_zero_i;
  assign drive_now = half_q ? (cur_bit || !saw_first_q) : cur_bit;
  assign lose_now  = close && half_q && !drove_q && saw_first_q && hit_second;
  assign advance   = close && half_q && !lose_now;

  iso_bit_cursor #(.ID_W(ID_W), .LSB_FIRST(LSB_FIRST)) u_cursor (
    .clk     (clk),
    .rst     (rst),
    .clear   (wake_zero_i),
    .advance (advance),
    .id_i    (id_i),
    .cur_bit (cur_bit),
    .last    (last)
  );

  iso_line_sense u_sense (
    .sdl_i      (sdl_i),
    .hit_first  (hit_first),
    .hit_second (hit_second)
  );

  iso_drive_reg u_drive (
    .clk        (clk),
    .rst        (rst),
    .load       (accept),
    .drop       (win_q || wake_zero_i),
    .sel_second (half_q),
    .en_val     (drive_now),
    .drv_data_o (drv_data_o),
    .drv_en_o   (drv_en_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_SLEEP;
      win_q       <= 1'b0;
      half_q      <= 1'b0;
      drove_q     <= 1'b0;
      saw_first_q <= 1'b0;
    end else if (wake_zero_i) begin
      st_q        <= ST_COMPETE;
      win_q       <= 1'b0;
      half_q      <= 1'b0;
      drove_q     <= 1'b0;
      saw_first_q <= 1'b0;
    end else begin
      if (accept) begin
        win_q   <= 1'b1;
        drove_q <= drive_now;
      end
      if (close) begin
        win_q <= 1'b0;
        if (!half_q) begin
          saw_first_q <= !drove_q && hit_first;
          half_q      <= 1'b1;
        end else begin
          half_q <= 1'b0;
          if (lose_now) begin
            st_q <= ST_LOST;
          end else if (last) begin
            st_q <= ST_WON;
          end
        end
      end
    end
  end

  assign lost_o     = (st_q == ST_LOST);
  assign isolated_o = (st_q == ST_WON);
endmodule

// File: rtl/iso_arb_chk.sv
module iso_arb_chk (
  input logic       clk,
  input logic       rst,
  input logic       wake_zero_i,
  input logic       iso_rd_i,
  input logic [7:0] drv_data_o,
  input logic       drv_en_o,
  input logic       lost_o,
  input logic       isolated_o
);
  assert_quiet_data_R9: assert property (@(posedge clk) disable iff (rst)
    !drv_en_o |-> drv_data_o == 8'h00);

  assert_cause_R9: assert property (@(posedge clk) disable iff (rst)
    drv_en_o |-> ($past(iso_rd_i) && !$past(wake_zero_i)));

  assert_pattern_R2: assert property (@(posedge clk) disable iff (rst)
    drv_en_o |-> (drv_data_o == 8'h55 || drv_data_o == 8'hAA));

  assert_single_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    drv_en_o |=> !drv_en_o);

  assert_lost_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    lost_o |-> !drv_en_o);

  assert_lost_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (lost_o && !wake_zero_i) |=> lost_o);

  assert_won_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    isolated_o |-> !drv_en_o);

  assert_won_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (isolated_o && !wake_zero_i) |=> isolated_o);

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(lost_o && isolated_o));

  assert_wake_clears_R7: assert property (@(posedge clk) disable iff (rst)
    wake_zero_i |=> (!lost_o && !isolated_o && !drv_en_o));
endmodule

bind isolation_bit_arbiter iso_arb_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .wake_zero_i (wake_zero_i),
  .iso_rd_i    (iso_rd_i),
  .drv_data_o  (drv_data_o),
  .drv_en_o    (drv_en_o),
  .lost_o      (lost_o),
  .isolated_o  (isolated_o)
);

// File: tb/sim_isolation_bit_arbiter.sv
`timescale 1ns/1ps
module sim_isolation_bit_arbiter;
  localparam int ID_W  = 72;
  localparam int NCARD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wake = 1'b0;
  logic rd = 1'b0;
  logic [1:0] sdl;
  logic [ID_W-1:0] ids [NCARD];
  logic [7:0] dd [NCARD];
  logic en [NCARD];
  logic lo [NCARD];
  logic iz [NCARD];
  bit alive [NCARD];
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  isolation_bit_arbiter #(.ID_W(ID_W)) u0 (.clk(clk), .rst(rst), .wake_zero_i(wake),
    .iso_rd_i(rd), .sdl_i(sdl), .id_i(ids[0]), .drv_data_o(dd[0]), .drv_en_o(en[0]),
    .lost_o(lo[0]), .isolated_o(iz[0]));
  isolation_bit_arbiter #(.ID_W(ID_W)) u1 (.clk(clk), .rst(rst), .wake_zero_i(wake),
    .iso_rd_i(rd), .sdl_i(sdl), .id_i(ids[1]), .drv_data_o(dd[1]), .drv_en_o(en[1]),
    .lost_o(lo[1]), .isolated_o(iz[1]));
  isolation_bit_arbiter #(.ID_W(ID_W)) u2 (.clk(clk), .rst(rst), .wake_zero_i(wake),
    .iso_rd_i(rd), .sdl_i(sdl), .id_i(ids[2]), .drv_data_o(dd[2]), .drv_en_o(en[2]),
    .lost_o(lo[2]), .isolated_o(iz[2]));
  isolation_bit_arbiter #(.ID_W(ID_W)) u3 (.clk(clk), .rst(rst), .wake_zero_i(wake),
    .iso_rd_i(rd), .sdl_i(sdl), .id_i(ids[3]), .drv_data_o(dd[3]), .drv_en_o(en[3]),
    .lost_o(lo[3]), .isolated_o(iz[3]));

  // open-collector lines modelled as a wired OR
  always_comb begin
    sdl = 2'b00;
    for (int i = 0; i < NCARD; i++) if (en[i]) sdl = sdl | dd[i][1:0];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [ID_W-1:0] rand_id();
    logic [95:0] r;
    r = {$urandom(), $urandom(), $urandom()};
    return r[ID_W-1:0];
  endfunction

  function automatic bit any_one(input int b);
    bit f = 1'b0;
    for (int i = 0; i < NCARD; i++) if (alive[i] && ids[i][b]) f = 1'b1;
    return f;
  endfunction

  task automatic do_read(input bit exp_en, input logic [7:0] pat, input bit hold2,
                         input string req);
    logic [7:0] exp_d;
    exp_d = exp_en ? pat : 8'h00;
    @(negedge clk) rd = 1'b1;
    @(negedge clk) if (!hold2) rd = 1'b0;
    check(en[0] == exp_en, req, int'(en[0]), int'(exp_en));
    check(dd[0] == exp_d, req, int'(dd[0]), int'(exp_d));
    if (hold2) begin
      @(negedge clk) rd = 1'b0;
      check(en[0] == 1'b0, "R8 strobe in window", int'(en[0]), 0);
    end else begin
      @(negedge clk);
    end
  endtask

  task automatic run_round(input int nbits, input bit combo, input int hold_bit);
    bit ones;
    @(negedge clk) begin wake = 1'b1; rd = combo; end
    @(negedge clk) begin wake = 1'b0; rd = 1'b0; end
    check(en[0] == 1'b0, "R7 wake beats strobe", int'(en[0]), 0);
    check(!lo[0] && !iz[0], "R7 wake clears flags", int'({lo[0], iz[0]}), 0);
    for (int i = 0; i < NCARD; i++) alive[i] = 1'b1;
    for (int b = 0; b < nbits; b++) begin
      ones = any_one(b);
      do_read(alive[0] && ids[0][b], 8'h55, b == hold_bit, "R2 first read");
      do_read(alive[0] && (ids[0][b] || !ones), 8'hAA, 1'b0, "R3 second read");
      if (ones) for (int i = 0; i < NCARD; i++) alive[i] = alive[i] && ids[i][b];
      check(lo[0] == !alive[0], "R4 loss flag", int'(lo[0]), int'(!alive[0]));
    end
    if (nbits == ID_W) begin
      for (int i = 0; i < NCARD; i++) begin
        check(iz[i] == alive[i], "R5 isolated", int'(iz[i]), int'(alive[i]));
        check(lo[i] == !alive[i], "R5 lost at end", int'(lo[i]), int'(!alive[i]));
      end
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NCARD; i++) ids[i] = rand_id();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!en[0] && !lo[0] && !iz[0], "R1 reset state", int'({en[0], lo[0], iz[0]}), 0);
    do_read(1'b0, 8'h55, 1'b0, "R1 strobe before wake");
    check(dd[0] == 8'h00, "R9 idle data", int'(dd[0]), 0);

    // random contests
    for (int r = 0; r < 5; r++) begin
      for (int i = 0; i < NCARD; i++) ids[i] = rand_id();
      run_round(ID_W, 1'b0, -1);
    end

    // two cards identical up to the final bit
    ids[0] = rand_id(); ids[0][ID_W-1] = 1'b1;
    ids[1] = ids[0];    ids[1][ID_W-1] = 1'b0;
    ids[2] = '0; ids[3] = '0;
    run_round(ID_W, 1'b0, -1);
    check(iz[0] == 1'b1, "R5 last bit decides", int'(iz[0]), 1);

    // winner ignores further reads
    do_read(1'b0, 8'h55, 1'b0, "R6 read after win");
    check(iz[0] == 1'b1, "R6 stays isolated", int'(iz[0]), 1);

    // u0 loses, then ignores reads
    ids[0] = '0;
    for (int i = 1; i < NCARD; i++) ids[i] = rand_id();
    run_round(ID_W, 1'b0, -1);
    do_read(1'b0, 8'h55, 1'b0, "R4 read after loss");
    check(lo[0] == 1'b1, "R4 stays lost", int'(lo[0]), 1);

    // wake part way through restarts from bit 0
    for (int i = 0; i < NCARD; i++) ids[i] = rand_id();
    run_round(11, 1'b0, -1);
    run_round(ID_W, 1'b0, -1);

    // wake and strobe in one cycle; strobe held into window
    for (int i = 0; i < NCARD; i++) ids[i] = rand_id();
    run_round(ID_W, 1'b1, 5);
    for (int i = 0; i < NCARD; i++) ids[i] = rand_id();
    run_round(ID_W, 1'b1, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule